// File: doc/BRIEF.md
# Test-Against-Zero Instruction Sequencer

This block carries out one instruction of a 16-bit-bus processor core: it tests an operand against zero and updates the four arithmetic condition flags. It takes one instruction word and decodes it into an operand size (byte, word or long) and an addressing mode. The supported modes are data register direct, address register indirect, and address register indirect with post-increment. When the operand lives in memory, the block fetches it over a 16-bit data bus that uses a request/acknowledge handshake. It then sets the negative and zero flags from the operand and clears the overflow and carry flags. In post-increment mode it also writes the stepped address back to the register file. Each instruction ends with one program prefetch bus cycle at the address given on the `pc` input.

The surrounding core offers an instruction word together with a one-cycle `start` strobe while `idle` is high. The core supplies register contents through a combinational read port, and it gets one write strobe for the post-increment write-back. The block raises `done` for one cycle once the prefetch has been acknowledged. An instruction word that the block cannot execute raises `illegal` for one cycle instead, and the block does nothing else.

Top module: `tstz_seq`

## Requirements
- R1: An instruction word is accepted when (word & 0xFFC0) is 0x4A00, 0x4A40 or 0x4A80, meaning size bits 7:6 equal to 00 (byte), 01 (word) or 10 (long). Bits 5:3 give the mode: 000 for a data register, 010 for indirect, 011 for post-increment. Bits 2:0 give the register number.
- R2: Every executed instruction clears the overflow flag and the carry flag.
- R3: The negative flag takes operand bit 7 for byte size, bit 15 for word size and bit 31 for long size.
- R4: The zero flag is set exactly when the low 8, the low 16 or all 32 operand bits are zero, for byte, word and long size respectively.
- R5: Register file index 0-7 selects data registers and index 8-15 selects address registers. In data register mode no operand bus read is made. The only bus cycle is one prefetch with `bus_prog`=1 at address `pc`.
- R6: Byte or word size in a memory mode makes exactly one read at the address register value. For a byte, an odd address selects bus bits 7:0 and an even address selects bits 15:8.
- R7: Long size in a memory mode reads the high half at the address register value and then the low half at that value plus 2.
- R8: Post-increment mode writes the address register (index 8+n) plus 1, 2 or 4 for byte, word or long. Indirect mode and data register mode write nothing.
- R9: An unaccepted word, or an unsupported mode, pulses `illegal` for one cycle and starts no bus cycle. The flags keep their values.
- R10: `done` is high for exactly one cycle, starting the cycle after the prefetch acknowledge. A `start` is ignored while `idle` is low.
- R11: Once `bus_req` is raised, it and `bus_addr` stay stable until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Offer of a new instruction word |
| instr | input | 16 | Instruction word |
| pc | input | ADDR_W | Prefetch address |
| idle | output | 1 | Ready for a new instruction |
| rf_rd_idx | output | 4 | Register read index |
| rf_rd_data | input | 32 | Register read data (combinational) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| bus_req | output | 1 | Bus cycle request |
| bus_prog | output | 1 | Request is a program prefetch |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | 16 | Bus read data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Instruction word rejected |

## Verification
The bench uses operands whose sign and zero results differ with the operand width, such as 0x80 and 0x00010000. A design that masks with the wrong width, or takes the sign from the wrong bit, therefore reports visibly wrong flags. Byte reads at an even and an odd address catch a swapped byte lane. A long operand whose high half is zero but whose low half is not catches a design that drops the second read. The bench compares each post-increment write-back against the expected step of 1, 2 or 4, and checks the address of each read, so a wrong step or a wrong second read address shows up. An unsupported mode, a reserved size and a foreign opcode each test that the design leaves the flags alone and starts no bus cycle. A start offered mid-instruction tests that the design neither restarts nor produces a second `done`.

// File: rtl/tstz_pkg.sv
package tstz_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } opsize_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HI,
        ST_RD_LO,
        ST_EVAL,
        ST_PREF
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        opsize_e     size;
        logic        postinc;
        logic [2:0]  regn;
        logic [31:0] ea;
        logic [31:0] opnd;
        logic        fn;
        logic        fz;
        logic        fv;
        logic        fc;
        logic        done;
        logic        illegal;
    } seq_regs_t;

    localparam logic [15:0] OPC_MASK  = 16'hFFC0;
    localparam logic [15:0] OPC_BYTE  = 16'h4A00;
    localparam logic [15:0] OPC_WORD  = 16'h4A40;
    localparam logic [15:0] OPC_LONG  = 16'h4A80;
    localparam logic [2:0]  MODE_DREG = 3'b000;
    localparam logic [2:0]  MODE_IND  = 3'b010;
    localparam logic [2:0]  MODE_PINC = 3'b011;

endpackage

// File: rtl/tstz_decode.sv
module tstz_decode
    import tstz_pkg::*;
(
    input  logic [15:0] instr,
    output logic        legal,
    output opsize_e     size,
    output logic        mem_mode,
    output logic        postinc,
    output logic [2:0]  regn
);
    logic [15:0] masked;
    logic        op_ok;
    logic        mode_ok;
    logic [2:0]  mode;

    always_comb begin
        masked  = instr & OPC_MASK;
        mode    = instr[5:3];
        regn    = instr[2:0];
        size    = SZ_BYTE;
        op_ok   = 1'b1;
        if (masked == OPC_BYTE)      size = SZ_BYTE;
        else if (masked == OPC_WORD) size = SZ_WORD;
        else if (masked == OPC_LONG) size = SZ_LONG;
        else                         op_ok = 1'b0;
        mode_ok  = (mode == MODE_DREG) || (mode == MODE_IND) || (mode == MODE_PINC);
        mem_mode = (mode == MODE_IND) || (mode == MODE_PINC);
        postinc  = (mode == MODE_PINC);
        legal    = op_ok && mode_ok;
    end
endmodule

// File: rtl/tstz_flags.sv
module tstz_flags
    import tstz_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opsize_e           size,
    input  logic [DATA_W-1:0] opnd,
    output logic              neg,
    output logic              zero
);
    localparam int NSZ = 3;
    logic [NSZ-1:0] neg_w;
    logic [NSZ-1:0] zero_w;

    for (genvar g = 0; g < NSZ; g++) begin : g_width
        localparam int W = (8 << g) > DATA_W ? DATA_W : (8 << g);
        assign neg_w[g]  = opnd[W-1];
        assign zero_w[g] = (opnd[W-1:0] == '0);
    end

    always_comb begin
        unique case (size)
            SZ_WORD: begin neg = neg_w[1]; zero = zero_w[1]; end
            SZ_LONG: begin neg = neg_w[2]; zero = zero_w[2]; end
            default: begin neg = neg_w[0]; zero = zero_w[0]; end
        endcase
    end
endmodule

// File: rtl/tstz_seq.sv
module tstz_seq
    import tstz_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic [ADDR_W-1:0] pc,
    output logic              idle,
    output logic [3:0]        rf_rd_idx,
    input  logic [31:0]       rf_rd_data,
    output logic              rf_wr_en,
    output logic [3:0]        rf_wr_idx,
    output logic [31:0]       rf_wr_data,
    output logic              bus_req,
    output logic              bus_prog,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [15:0]       bus_rdata,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              done,
    output logic              illegal
);
    localparam int DATA_W = 32;

    seq_regs_t r_d, r_q;

    logic    dec_legal, dec_mem, dec_pinc;
    opsize_e dec_size;
    logic [2:0] dec_regn;
    logic    ev_neg, ev_zero;
    logic [31:0] step;
    logic [7:0]  lane;

    tstz_decode u_dec (
        .instr    (instr),
        .legal    (dec_legal),
        .size     (dec_size),
        .mem_mode (dec_mem),
        .postinc  (dec_pinc),
        .regn     (dec_regn)
    );

    tstz_flags #(.DATA_W(DATA_W)) u_flg (
        .size (r_q.size),
        .opnd (r_q.opnd),
        .neg  (ev_neg),
        .zero (ev_zero)
    );

    always_comb begin
        unique case (r_q.size)
            SZ_WORD: step = 32'd2;
            SZ_LONG: step = 32'd4;
            default: step = 32'd1;
        endcase
        lane = r_q.ea[0] ? bus_rdata[7:0] : bus_rdata[15:8];
    end

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.illegal = 1'b0;
        bus_req     = 1'b0;
        bus_prog    = 1'b0;
        bus_addr    = '0;
        rf_wr_en    = 1'b0;
        rf_wr_idx   = {1'b1, r_q.regn};
        rf_wr_data  = r_q.ea + step;
        rf_rd_idx   = {dec_mem, dec_regn};

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (!dec_legal) begin
                        r_d.illegal = 1'b1;
                    end else begin
                        r_d.size    = dec_size;
                        r_d.postinc = dec_pinc;
                        r_d.regn    = dec_regn;
                        if (dec_mem) begin
                            r_d.ea    = rf_rd_data;
                            r_d.opnd  = '0;
                            r_d.state = ST_RD_HI;
                        end else begin
                            r_d.opnd  = rf_rd_data;
                            r_d.state = ST_EVAL;
                        end
                    end
                end
            end
            ST_RD_HI: begin
                bus_req  = 1'b1;
                bus_addr = r_q.ea[ADDR_W-1:0];
                if (bus_ack) begin
                    unique case (r_q.size)
                        SZ_BYTE: begin
                            r_d.opnd  = {24'd0, lane};
                            r_d.state = ST_EVAL;
                        end
                        SZ_WORD: begin
                            r_d.opnd  = {16'd0, bus_rdata};
                            r_d.state = ST_EVAL;
                        end
                        default: begin
                            r_d.opnd  = {bus_rdata, 16'd0};
                            r_d.state = ST_RD_LO;
                        end
                    endcase
                end
            end
            ST_RD_LO: begin
                bus_req  = 1'b1;
                bus_addr = r_q.ea[ADDR_W-1:0] + ADDR_W'(2);
                if (bus_ack) begin
                    r_d.opnd[15:0] = bus_rdata;
                    r_d.state      = ST_EVAL;
                end
            end
            ST_EVAL: begin
                r_d.fn    = ev_neg;
                r_d.fz    = ev_zero;
                r_d.fv    = 1'b0;
                r_d.fc    = 1'b0;
                rf_wr_en  = r_q.postinc;
                r_d.state = ST_PREF;
            end
            ST_PREF: begin
                bus_req  = 1'b1;
                bus_prog = 1'b1;
                bus_addr = pc;
                if (bus_ack) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.size    <= SZ_BYTE;
            r_q.postinc <= 1'b0;
            r_q.regn    <= '0;
            r_q.ea      <= '0;
            r_q.opnd    <= '0;
            r_q.fn      <= 1'b0;
            r_q.fz      <= 1'b0;
            r_q.fv      <= 1'b0;
            r_q.fc      <= 1'b0;
            r_q.done    <= 1'b0;
            r_q.illegal <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle    = (r_q.state == ST_IDLE);
    assign flag_n  = r_q.fn;
    assign flag_z  = r_q.fz;
    assign flag_v  = r_q.fv;
    assign flag_c  = r_q.fc;
    assign done    = r_q.done;
    assign illegal = r_q.illegal;

endmodule

// File: rtl/tstz_chk.sv
module tstz_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_prog,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rf_wr_en,
    input logic              done,
    input logic              illegal,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr)) else $error("req dropped"); // R11

    AST_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_v && !flag_c) else $error("v/c set"); // R2

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done long"); // R10

    AST_DONE_AFTER_PF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_prog && bus_ack)) else $error("done early"); // R10

    AST_ILL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal) else $error("illegal long"); // R9

    AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !bus_req && $stable({flag_n, flag_z, flag_v, flag_c})) else $error("illegal acted"); // R9

    AST_WB_THEN_PF: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> bus_req && bus_prog) else $error("no prefetch"); // R8
endmodule

bind tstz_seq tstz_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_prog (bus_prog),
    .bus_addr (bus_addr),
    .rf_wr_en (rf_wr_en),
    .done     (done),
    .illegal  (illegal),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_c   (flag_c)
);

// File: tb/sim_tstz_seq.sv
`timescale 1ns/1ps
module sim_tstz_seq;
    localparam int AW = 24;
    localparam logic [AW-1:0] PC = 24'h000400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] instr = 16'h0;
    logic idle, rf_wr_en, bus_req, bus_prog, bus_ack = 1'b0;
    logic [3:0] rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_rdata;
    logic fn, fz, fv, fc, done, illegal;

    logic [31:0] rf [16];
    logic [15:0] mem [64];

    int total = 0, bad = 0, cyc = 0;
    int n_rd, n_pf, n_wr, n_done;
    logic [AW-1:0] rd_a [2];
    logic [AW-1:0] pf_a;

    always #2.5 clk = ~clk;

    assign rf_rd_data = rf[rf_rd_idx];
    assign bus_rdata  = mem[bus_addr[6:1]];

    tstz_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(PC),
        .idle(idle), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .bus_req(bus_req), .bus_prog(bus_prog), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc),
        .done(done), .illegal(illegal)
    );

    always @(posedge clk) begin
        bus_ack <= bus_req && !bus_ack;
        if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
        if (bus_req && bus_ack) begin
            if (bus_prog) begin n_pf++; pf_a = bus_addr; end
            else begin
                if (n_rd < 2) rd_a[n_rd] = bus_addr;
                n_rd++;
            end
        end
        if (rf_wr_en) n_wr++;
        if (done) n_done++;
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_state();
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        rf[0] = 32'h00000080; rf[1] = 32'h00010000;
        rf[2] = 32'h80000000; rf[3] = 32'h00008000;
        rf[8] = 32'h10; rf[9] = 32'h21; rf[10] = 32'h30;
        rf[11] = 32'h32; rf[12] = 32'h20;
        for (int i = 0; i < 64; i++) mem[i] = 16'h5555;
        mem[8] = 16'h8001; mem[9] = 16'h0000; mem[16] = 16'h00FF;
        mem[24] = 16'h0000; mem[25] = 16'h0000; mem[26] = 16'h1234;
    endtask

    task automatic issue(input logic [15:0] w);
        @(negedge clk);
        n_rd = 0; n_pf = 0; n_wr = 0; n_done = 0;
        instr = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [15:0] w;
        logic        n;
        logic        z;
        logic [1:0]  nrd;
        logic [7:0]  a0;
        logic        wb;
        logic [7:0]  wbv;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{16'h4A00, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00},
        '{16'h4A40, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00},
        '{16'h4A01, 1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00},
        '{16'h4A41, 1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 8'h00},
        '{16'h4A81, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00},
        '{16'h4A82, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00},
        '{16'h4A43, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00},
        '{16'h4A10, 1'b1, 1'b0, 2'd1, 8'h10, 1'b0, 8'h00},
        '{16'h4A50, 1'b1, 1'b0, 2'd1, 8'h10, 1'b0, 8'h00},
        '{16'h4A90, 1'b1, 1'b0, 2'd2, 8'h10, 1'b0, 8'h00},
        '{16'h4A19, 1'b1, 1'b0, 2'd1, 8'h21, 1'b1, 8'h22},
        '{16'h4A5A, 1'b0, 1'b1, 2'd1, 8'h30, 1'b1, 8'h32},
        '{16'h4A9A, 1'b0, 1'b1, 2'd2, 8'h30, 1'b1, 8'h34},
        '{16'h4A9B, 1'b0, 1'b0, 2'd2, 8'h32, 1'b1, 8'h36},
        '{16'h4A14, 1'b0, 1'b1, 1'd1, 8'h20, 1'b0, 8'h00}
    };

    logic [3:0] snap;
    bit ok;

    initial begin
        load_state();
        repeat (3) @(negedge clk);
        // reset state
        check("R10 reset idle", idle, 1);
        check("R10 reset done", done, 0);
        check("R11 reset req", bus_req, 0);
        check("R2 reset flags", {fn, fz, fv, fc}, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            load_state();
            issue(VEC[k].w);
            wait_done(ok);
            check($sformatf("R10 done seen v%0d", k), ok, 1);
            check($sformatf("R3 flag_n v%0d", k), fn, VEC[k].n);
            check($sformatf("R4 flag_z v%0d", k), fz, VEC[k].z);
            check($sformatf("R2 v/c v%0d", k), {fv, fc}, 0);
            check($sformatf("R5 R6 R7 reads v%0d", k), n_rd, VEC[k].nrd);
            check($sformatf("R5 prefetch v%0d", k), {n_pf, pf_a}, {32'd1, PC});
            if (VEC[k].nrd != 0)
                check($sformatf("R6 first addr v%0d", k), rd_a[0], VEC[k].a0);
            if (VEC[k].nrd == 2)
                check($sformatf("R7 second addr v%0d", k), rd_a[1], VEC[k].a0 + 2);
            check($sformatf("R8 writes v%0d", k), n_wr, VEC[k].wb);
            if (VEC[k].wb)
                check($sformatf("R8 new An v%0d", k), rf[8 + VEC[k].w[2:0]], VEC[k].wbv);
            else if (VEC[k].nrd != 0)
                check($sformatf("R8 An kept v%0d", k), rf[8 + VEC[k].w[2:0]], VEC[k].a0);
            @(negedge clk);
            check($sformatf("R10 done width v%0d", k), done, 0);
        end

        // illegal words: An mode, reserved size, foreign opcode
        load_state();
        issue(16'h4A00);
        wait_done(ok);
        snap = {fn, fz, fv, fc};
        foreach (snap[i]) ;
        for (int j = 0; j < 3; j++) begin
            logic [15:0] bw;
            bw = (j == 0) ? 16'h4A08 : (j == 1) ? 16'h4AC0 : 16'h4B10;
            issue(bw);
            check($sformatf("R9 illegal pulse %0h", bw), illegal, 1);
            @(negedge clk);
            check($sformatf("R9 illegal cleared %0h", bw), illegal, 0);
            check($sformatf("R9 flags kept %0h", bw), {fn, fz, fv, fc}, snap);
            repeat (3) @(negedge clk);
            check($sformatf("R9 no bus %0h", bw), n_rd + n_pf, 0);
            check($sformatf("R1 idle after %0h", bw), idle, 1);
        end

        // start while busy is ignored
        load_state();
        issue(16'h4A10);
        start = 1'b1; instr = 16'h4A01;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        check("R10 busy done", ok, 1);
        check("R10 busy flags", {fn, fz}, 2'b10);
        repeat (10) @(negedge clk);
        check("R10 single done", n_done, 1);
        check("R10 busy reads", n_rd, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule